// File: doc/BRIEF.md
# Boot Image Copy Engine

The block keeps a short boot program in a small local SRAM that stays powered while the rest of the chip sleeps. On request it moves a programmable run of dwords out of that SRAM into a target instruction memory. Software fills the SRAM through a byte-addressed register window. It then sets a source dword index, a destination dword address and a dword count, and writes a control word to start the transfer.

Software can poll for completion in two ways: the start bit drops back to zero, or a done flag is raised in a status register. A separate arm bit in the control word lets the same transfer repeat automatically on every pulse of a power-up input, so the boot program is reinstalled after each sleep with no further software writes. While a transfer runs, the engine owns the SRAM port and the transfer parameters are frozen.

Host reads return data one cycle after the read strobe, qualified by a valid flag. The register window decodes byte addresses below 0x400. The SRAM window occupies 0x400 to 0x7FF, and the dword index there is address bits 9:2.

Top module: `bootcopy_engine`

## Requirements
- R1: After reset every register reads zero and no instruction-memory write is issued.
- R2: Registers sit at byte offsets 0x00 control, 0x04 source index (bits 7:0), 0x08 destination address (bits 15:0), 0x0C dword count (bits 8:0) and 0x10 status (bit 0 = done). Wider write data is truncated to the field. Read data appears on cfg_rdata with cfg_rvalid high in the cycle after cfg_rd.
- R3: Writes to 0x400–0x7FF store a dword in local SRAM entry addr[9:2], and reads from that range return the stored dword.
- R4: A copy writes exactly count dwords to the instruction memory in ascending order. Dword k carries SRAM entry (source+k) mod 256 and goes to destination address destination+k.
- R5: Control bit 31 (start) reads 1 from launch until the copy ends. It clears on the same clock edge that sets status bit 0.
- R6: Every launch clears the status done bit.
- R7: A count of zero completes without any instruction-memory write.
- R8: While a copy runs, writes to the source, destination and count registers are ignored, and a further start write causes no second copy.
- R9: With control bit 30 (arm) set, a pulse on pwr_up while idle launches a copy with the current parameters. With arm clear, pwr_up is ignored.
- R10: While a copy runs, host writes to the SRAM window are dropped and host reads of it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Host write strobe |
| cfg_rd | input | 1 | Host read strobe |
| cfg_addr | input | 12 | Host byte address |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read data, valid the cycle after cfg_rd |
| cfg_rvalid | output | 1 | High when cfg_rdata holds a read result |
| pwr_up | input | 1 | Power-up event pulse |
| imem_we | output | 1 | Instruction-memory write enable |
| imem_addr | output | 16 | Instruction-memory dword address |
| imem_wdata | output | 32 | Instruction-memory write data |

## Verification
The assertions assume the host never raises cfg_wr and cfg_rd in the same cycle, and that strobes address dword-aligned locations. They also assume pwr_up is a level sampled on the clock, so a pulse wider than one cycle can only relaunch after the previous copy ends. The stimulus drives every strobe for exactly one cycle on the falling edge, uses only aligned offsets, and pulses pwr_up for one cycle at a time. Busy-time writes are issued well inside a 200-dword copy, so they always land while the engine owns the SRAM.

// File: rtl/bootcopy_pkg.sv
`timescale 1ns/1ps
package bootcopy_pkg;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_RUN
  } seq_state_t;

  typedef enum logic [1:0] {
    RSEL_REG,
    RSEL_SRAM,
    RSEL_ZERO
  } rsel_t;

  // dword index of each register inside the register window
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_SRC  = 3'd1,
    REG_DST  = 3'd2,
    REG_CNT  = 3'd3,
    REG_STAT = 3'd4
  } reg_sel_t;

endpackage

// File: rtl/bootcopy_sram.sv
`timescale 1ns/1ps
module bootcopy_sram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // single port, registered read; array carries no reset (retained storage)
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[idx] <= wdata;
      end else begin
        rdata_q <= mem[idx];
      end
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/bootcopy_seq.sv
`timescale 1ns/1ps
module bootcopy_seq
  import bootcopy_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  parameter int DST_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [IDX_W-1:0] go_src,
  input  logic [DST_W-1:0] go_dst,
  input  logic [CNT_W-1:0] go_cnt,
  input  logic [DW-1:0]    sram_rdata,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             finish,
  output logic             imem_we,
  output logic [DST_W-1:0] imem_addr,
  output logic [DW-1:0]    imem_wdata
);

  seq_state_t       state_q, state_n;
  logic [IDX_W-1:0] src_q, src_n;
  logic [DST_W-1:0] dst_q, dst_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             pend_q, pend_n;
  logic [DST_W-1:0] paddr_q, paddr_n;
  logic             run_en;

  // read of entry k and write of entry k-1 overlap: one dword per cycle
  always_comb begin
    state_n = state_q;
    src_n   = src_q;
    dst_n   = dst_q;
    rem_n   = rem_q;
    pend_n  = 1'b0;
    paddr_n = paddr_q;
    rd_en   = 1'b0;
    finish  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (go) begin
          state_n = SEQ_RUN;
          src_n   = go_src;
          dst_n   = go_dst;
          rem_n   = go_cnt;
        end
      end
      SEQ_RUN: begin
        if (rem_q != '0) begin
          rd_en   = 1'b1;
          src_n   = src_q + 1'b1;
          dst_n   = dst_q + 1'b1;
          rem_n   = rem_q - 1'b1;
          pend_n  = 1'b1;
          paddr_n = dst_q;
        end else begin
          finish  = 1'b1;
          state_n = SEQ_IDLE;
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  assign run_en = go | (state_q == SEQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      paddr_q <= '0;
    end else if (run_en) begin
      state_q <= state_n;
      src_q   <= src_n;
      dst_q   <= dst_n;
      rem_q   <= rem_n;
      paddr_q <= paddr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
    end
  end

  assign rd_idx     = src_q;
  assign imem_we    = pend_q;
  assign imem_addr  = paddr_q;
  assign imem_wdata = sram_rdata;

  // R4: back-to-back writes step the destination by one
  assert_dst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_we && $past(imem_we)) |-> (imem_addr == $past(imem_addr) + 1'b1));

  // R7: zero-count launch finishes next cycle without reading the SRAM
  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && go && go_cnt == '0) |=> (finish && !rd_en));

endmodule

// File: rtl/bootcopy_regs.sv
`timescale 1ns/1ps
module bootcopy_regs
  import bootcopy_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DW     = 32,
  parameter int DST_W  = 16,
  parameter int ADDR_W = 12,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = IDX_W + 1,
  localparam int START_BIT = DW - 1,
  localparam int ARM_BIT   = DW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              cfg_rvalid,
  input  logic              pwr_up,
  input  logic [DW-1:0]     sram_rdata,
  input  logic              seq_finish,
  output logic              launch,
  output logic              busy,
  output logic [IDX_W-1:0]  src,
  output logic [DST_W-1:0]  dst,
  output logic [CNT_W-1:0]  cnt,
  output logic              host_sram_en,
  output logic              host_sram_we,
  output logic [IDX_W-1:0]  host_sram_idx
);

  logic             start_q, start_n;
  logic             done_q, done_n;
  logic             arm_q, arm_n;
  logic [IDX_W-1:0] src_q, src_n;
  logic [DST_W-1:0] dst_q, dst_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DW-1:0]    rdq_q, rdq_n;
  rsel_t            rsel_q, rsel_n;
  logic             rvalid_q;

  logic             is_reg, is_win, reg_hit;
  logic [IDX_W-1:0] word_idx;
  logic             wr_ctrl, wr_src, wr_dst, wr_cnt, start_req;
  logic [DW-1:0]    reg_view;
  logic             unused_bits;

  assign unused_bits = ^{cfg_wdata[DW-3:DST_W], cfg_addr[1:0]};

  assign is_reg   = (cfg_addr[ADDR_W-1:IDX_W+2] == '0);
  assign is_win   = (cfg_addr[ADDR_W-1:IDX_W+2] == 1);
  assign word_idx = cfg_addr[IDX_W+1:2];
  assign reg_hit  = is_reg && (word_idx[IDX_W-1:3] == '0);

  assign wr_ctrl = cfg_wr && reg_hit && (word_idx[2:0] == REG_CTRL);
  assign wr_src  = cfg_wr && reg_hit && (word_idx[2:0] == REG_SRC);
  assign wr_dst  = cfg_wr && reg_hit && (word_idx[2:0] == REG_DST);
  assign wr_cnt  = cfg_wr && reg_hit && (word_idx[2:0] == REG_CNT);

  assign start_req = wr_ctrl && cfg_wdata[START_BIT];
  assign launch    = !start_q && (start_req || (pwr_up && arm_q));

  // control and status state
  always_comb begin
    start_n = start_q;
    done_n  = done_q;
    arm_n   = arm_q;
    if (launch) begin
      start_n = 1'b1;
      done_n  = 1'b0;
    end else if (seq_finish) begin
      start_n = 1'b0;
      done_n  = 1'b1;
    end
    if (wr_ctrl) begin
      arm_n = cfg_wdata[ARM_BIT];
    end
  end

  // parameter fields, frozen while busy
  always_comb begin
    src_n = src_q;
    dst_n = dst_q;
    cnt_n = cnt_q;
    if (!start_q) begin
      if (wr_src) src_n = cfg_wdata[IDX_W-1:0];
      if (wr_dst) dst_n = cfg_wdata[DST_W-1:0];
      if (wr_cnt) cnt_n = cfg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    reg_view = '0;
    if (reg_hit) begin
      case (word_idx[2:0])
        REG_CTRL: begin
          reg_view[START_BIT] = start_q;
          reg_view[ARM_BIT]   = arm_q;
        end
        REG_SRC:  reg_view = DW'(src_q);
        REG_DST:  reg_view = DW'(dst_q);
        REG_CNT:  reg_view = DW'(cnt_q);
        REG_STAT: reg_view[0] = done_q;
        default:  reg_view = '0;
      endcase
    end
  end

  always_comb begin
    rdq_n  = rdq_q;
    rsel_n = rsel_q;
    if (cfg_rd) begin
      if (is_win) begin
        rsel_n = start_q ? RSEL_ZERO : RSEL_SRAM;
      end else begin
        rsel_n = RSEL_REG;
        rdq_n  = reg_view;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      arm_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
    end else begin
      start_q <= start_n;
      done_q  <= done_n;
      arm_q   <= arm_n;
      src_q   <= src_n;
      dst_q   <= dst_n;
      cnt_q   <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdq_q    <= '0;
      rsel_q   <= RSEL_REG;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cfg_rd;
      if (cfg_rd) begin
        rdq_q  <= rdq_n;
        rsel_q <= rsel_n;
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RSEL_SRAM: cfg_rdata = sram_rdata;
      RSEL_ZERO: cfg_rdata = '0;
      default:   cfg_rdata = rdq_q;
    endcase
  end

  assign cfg_rvalid    = rvalid_q;
  assign busy          = start_q;
  assign src           = src_q;
  assign dst           = dst_q;
  assign cnt           = cnt_q;
  assign host_sram_en  = (cfg_wr || cfg_rd) && is_win && !start_q;
  assign host_sram_we  = cfg_wr && is_win && !start_q;
  assign host_sram_idx = word_idx;

  // R5: start and done never both set
  assert_start_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && done_q));

  // R5: start clears on the edge that raises done
  assert_done_with_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_q) |-> $rose(done_q));

  // R5: the sequencer only finishes a running copy
  assert_finish_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |-> start_q);

  // R8: parameters hold while busy
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_q) |-> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));

  // R9: an unarmed power-up event launches nothing
  assert_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up && !arm_q && !start_q && !start_req) |=> !start_q);

  // R2: read valid follows the strobe by one cycle
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid);

endmodule

// File: rtl/bootcopy_engine.sv
`timescale 1ns/1ps
module bootcopy_engine #(
  parameter int DEPTH  = 256,
  parameter int DW     = 32,
  parameter int DST_W  = 16,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              cfg_rvalid,
  input  logic              pwr_up,
  output logic              imem_we,
  output logic [DST_W-1:0]  imem_addr,
  output logic [DW-1:0]     imem_wdata
);

  logic             launch, busy, seq_finish;
  logic [IDX_W-1:0] src, host_idx, seq_idx, sram_idx;
  logic [DST_W-1:0] dst;
  logic [CNT_W-1:0] cnt;
  logic             host_en, host_we, seq_rd;
  logic             sram_en, sram_we;
  logic [DW-1:0]    sram_rdata;

  bootcopy_regs #(
    .DEPTH(DEPTH), .DW(DW), .DST_W(DST_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_rd        (cfg_rd),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .cfg_rvalid    (cfg_rvalid),
    .pwr_up        (pwr_up),
    .sram_rdata    (sram_rdata),
    .seq_finish    (seq_finish),
    .launch        (launch),
    .busy          (busy),
    .src           (src),
    .dst           (dst),
    .cnt           (cnt),
    .host_sram_en  (host_en),
    .host_sram_we  (host_we),
    .host_sram_idx (host_idx)
  );

  bootcopy_seq #(
    .DEPTH(DEPTH), .DW(DW), .DST_W(DST_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (launch),
    .go_src     (src),
    .go_dst     (dst),
    .go_cnt     (cnt),
    .sram_rdata (sram_rdata),
    .rd_en      (seq_rd),
    .rd_idx     (seq_idx),
    .finish     (seq_finish),
    .imem_we    (imem_we),
    .imem_addr  (imem_addr),
    .imem_wdata (imem_wdata)
  );

  // engine owns the port while busy; host access is gated off in the regs
  assign sram_en  = seq_rd | host_en;
  assign sram_we  = !seq_rd && host_we;
  assign sram_idx = seq_rd ? seq_idx : host_idx;

  bootcopy_sram #(
    .DEPTH(DEPTH), .DW(DW)
  ) u_sram (
    .clk   (clk),
    .en    (sram_en),
    .we    (sram_we),
    .idx   (sram_idx),
    .wdata (cfg_wdata),
    .rdata (sram_rdata)
  );

  // R4: instruction-memory writes only during a copy
  assert_write_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |-> busy);

  // R10: engine reads and host access never share the port
  assert_port_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_rd && host_en));

  // R1: no instruction-memory write in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !imem_we);

endmodule

// File: tb/bootcopy_engine_test.sv
`timescale 1ns/1ps
module bootcopy_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        pwr_up = 1'b0;
  logic        imem_we;
  logic [15:0] imem_addr;
  logic [31:0] imem_wdata;

  int errors = 0;
  int checks = 0;
  int imem_writes = 0;
  logic [47:0] exp_q[$];
  logic [31:0] mirror [256];

  always #2.5 clk = ~clk;

  bootcopy_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .pwr_up(pwr_up), .imem_we(imem_we),
    .imem_addr(imem_addr), .imem_wdata(imem_wdata)
  );

  function automatic logic [31:0] pat(int i);
    return (32'(i) * 32'h01000193) ^ 32'h5A5A0000;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic expect_copy(int s, int d, int n);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({16'(d + k), mirror[(s + k) % 256]});
    end
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int t = 0; t < 2000; t++) begin
      reg_rd(12'h000, v);
      if (!v[31]) break;
    end
  endtask

  task automatic pulse_pwr();
    @(negedge clk);
    pwr_up = 1'b1;
    @(negedge clk);
    pwr_up = 1'b0;
  endtask

  // scoreboard monitor: every write must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && imem_we) begin
      imem_writes++;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R4 unexpected write: actual=%h@%h expected=none",
                 imem_wdata, imem_addr);
      end else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        check("R4 copy addr", {16'h0, imem_addr}, {16'h0, e[47:32]});
        check("R4 copy data", imem_wdata, e[31:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(12'h000, v); check("R1 ctrl", v, 0);
    reg_rd(12'h004, v); check("R1 src", v, 0);
    reg_rd(12'h008, v); check("R1 dst", v, 0);
    reg_rd(12'h00C, v); check("R1 cnt", v, 0);
    reg_rd(12'h010, v); check("R1 status", v, 0);

    // R3 fill the SRAM window
    for (int i = 0; i < 256; i++) begin
      mirror[i] = pat(i);
      reg_wr(12'h400 + 12'(i * 4), pat(i));
    end
    reg_rd(12'h400, v); check("R3 sram[0]", v, pat(0));
    reg_rd(12'h444, v); check("R3 sram[17]", v, pat(17));
    reg_rd(12'h7FC, v); check("R3 sram[255]", v, pat(255));

    // R2 field widths, offsets and read valid
    reg_wr(12'h004, 32'hFFFF_FF05);
    reg_wr(12'h008, 32'h0003_1234);
    reg_wr(12'h00C, 32'h0000_0003);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = 12'h004;
    @(negedge clk);
    cfg_rd = 1'b0;
    check("R2 rvalid", {31'h0, cfg_rvalid}, 1);
    check("R2 src", cfg_rdata, 32'h05);
    reg_rd(12'h008, v); check("R2 dst", v, 32'h1234);
    reg_rd(12'h00C, v); check("R2 cnt", v, 32'h3);

    // R4 short copy, R5 completion
    expect_copy(5, 16'h1234, 3);
    reg_wr(12'h000, 32'h8000_0000);
    wait_idle();
    reg_rd(12'h010, v); check("R5 done after copy", v, 1);
    check("R4 short queue empty", exp_q.size(), 0);

    // R7 zero count
    reg_wr(12'h00C, 32'h0);
    reg_wr(12'h000, 32'h8000_0000);
    wait_idle();
    reg_rd(12'h010, v); check("R7 done zero count", v, 1);
    check("R7 writes so far", imem_writes, 3);

    // long wrapping copy with busy-time accesses: R4 R5 R6 R8 R10
    reg_wr(12'h004, 32'd100);
    reg_wr(12'h008, 32'h8000);
    reg_wr(12'h00C, 32'd200);
    expect_copy(100, 16'h8000, 200);
    reg_wr(12'h000, 32'h8000_0000);
    reg_rd(12'h010, v); check("R6 done cleared on launch", v, 0);
    reg_rd(12'h000, v); check("R5 start reads busy", v, 32'h8000_0000);
    reg_wr(12'h004, 32'd7);
    reg_wr(12'h008, 32'h0);
    reg_wr(12'h00C, 32'd1);
    reg_wr(12'h000, 32'h8000_0000);
    reg_wr(12'h40C, 32'hDEAD_BEEF);
    reg_rd(12'h400, v); check("R10 busy sram read zero", v, 0);
    wait_idle();
    reg_rd(12'h010, v); check("R5 done after long copy", v, 1);
    reg_rd(12'h004, v); check("R8 src frozen", v, 32'd100);
    reg_rd(12'h008, v); check("R8 dst frozen", v, 32'h8000);
    reg_rd(12'h00C, v); check("R8 cnt frozen", v, 32'd200);
    reg_rd(12'h40C, v); check("R10 busy sram write dropped", v, pat(3));
    check("R8 no second copy", imem_writes, 203);

    // R9 armed power-up relaunches, unarmed is ignored
    reg_wr(12'h004, 32'd0);
    reg_wr(12'h008, 32'h0040);
    reg_wr(12'h00C, 32'd4);
    reg_wr(12'h000, 32'h4000_0000);
    reg_rd(12'h000, v); check("R9 arm readback idle", v, 32'h4000_0000);
    expect_copy(0, 16'h0040, 4);
    pulse_pwr();
    wait_idle();
    reg_rd(12'h010, v); check("R9 done after auto copy", v, 1);
    expect_copy(0, 16'h0040, 4);
    pulse_pwr();
    wait_idle();
    check("R9 two auto copies", imem_writes, 211);
    reg_wr(12'h000, 32'h0);
    pulse_pwr();
    repeat (10) @(negedge clk);
    reg_rd(12'h000, v); check("R9 unarmed stays idle", v, 0);
    reg_rd(12'h010, v); check("R9 unarmed keeps done", v, 1);
    check("R9 unarmed no writes", imem_writes, 211);
    check("R4 queue drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule